// File: doc/BRIEF.md
# Write-Atomicity Agreement Checker

This block watches two agents that take turns writing and reading one shared address. It decides whether both agents agree on a single global order of the two barrier-time writes. Sequential consistency requires that they agree. Each agent draws its write data from its own value set, which does not overlap the other agent's set. The value an agent writes encodes where it stands relative to its barrier: before it, at it, or after it. A read that returns the other agent's barrier value therefore shows where that write fell relative to the reader's own barrier write.

For each agent the checker keeps two bits. The first records that the agent has seen the other agent's barrier value. The second records whether the agent's own barrier write came first in its view. Once both agents have made their observation, the two views must be opposite: exactly one agent may have its own write first. If both agents claim their own write came first, or both claim the other's came first, the agents disagree and a sticky error flag rises. A second sticky flag catches data that breaks the value-set scheme.

The checker sits passively on two access trace ports. A verification environment runs a barrier test program on the two agents and watches the two flags.

Top module: `wa_agree_chk`

## Requirements
- R1: After reset, `disagree`, `illegal` and all four per-agent bits are 0.
- R2: Agent 0 uses base value 0 and agent 1 uses base value 3. The phase code is 0 for before the barrier, 1 for at the barrier and 2 for after it. A legal write carries base + phase. A valid write with other data, or with phase code 3, sets `illegal` in the next cycle.
- R3: A valid read returning a value outside 0..5 sets `illegal` in the next cycle. A read returning any value in 0..5 does not.
- R4: A valid read returning the other agent's barrier value sets that agent's seen bit in the next cycle. For agent 0 this value is 4; for agent 1 it is 1. Reads of other values leave the seen bit clear.
- R5: The own-first bit is captured at that first read. It is 1 exactly when the agent made its own barrier write (phase 1, data base+1) in an earlier cycle. Later reads and writes leave it unchanged.
- R6: `disagree` rises in the cycle after both seen bits hold and the two own-first bits are equal. It stays 0 while they differ.
- R7: `disagree` and `illegal` stay set until reset.
- R8: A cycle with the valid input low changes no state, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a0_vld | input | 1 | Agent 0 access valid |
| a0_wr | input | 1 | Agent 0 access is a write (1) or a read (0) |
| a0_data | input | DATA_W | Agent 0 written or returned data |
| a0_phase | input | 2 | Agent 0 barrier phase code |
| a1_vld | input | 1 | Agent 1 access valid |
| a1_wr | input | 1 | Agent 1 access is a write (1) or a read (0) |
| a1_data | input | DATA_W | Agent 1 written or returned data |
| a1_phase | input | 2 | Agent 1 barrier phase code |
| disagree | output | 1 | Sticky order-disagreement flag |
| illegal | output | 1 | Sticky illegal-value flag |
| a0_seen | output | 1 | Agent 0 has seen agent 1's barrier value |
| a0_own_first | output | 1 | Agent 0 saw its own barrier write first |
| a1_seen | output | 1 | Agent 1 has seen agent 0's barrier value |
| a1_own_first | output | 1 | Agent 1 saw its own barrier write first |

## Verification
Each result is due one clock edge after the access that causes it. This holds for the seen and own-first bits, for `illegal`, and for `disagree` when the completing read arrives. No output needs a second register stage. The bench drives each access on a falling edge and checks on the next falling edge, so exactly one rising edge lies between stimulus and check. Stickiness and the no-effect cases are checked on later falling edges after idle cycles.

// File: rtl/wa_pkg.sv
package wa_pkg;
  // number of marker values per agent: before, at, after the barrier
  localparam int VALS_PER_AGENT = 3;

  localparam logic [1:0] PH_PRE  = 2'd0;
  localparam logic [1:0] PH_AT   = 2'd1;
  localparam logic [1:0] PH_POST = 2'd2;
  localparam logic [1:0] PH_RSV  = 2'd3;

  // first value of agent idx's private set
  function automatic int agent_base(int idx);
    return idx * VALS_PER_AGENT;
  endfunction

  // the value an agent must write in a given phase
  function automatic int mark_value(int base, int ph);
    return base + ph;
  endfunction

  // barrier-time value of an agent
  function automatic int barrier_value(int base);
    return base + 1;
  endfunction

  // membership of v in the set starting at base
  function automatic bit in_set(int base, int v);
    return (v >= base) && (v < base + VALS_PER_AGENT);
  endfunction
endpackage

// File: rtl/wa_agent_track.sv
module wa_agent_track #(
  parameter int DATA_W     = 3,
  parameter int OWN_BASE   = 0,
  parameter int OTHER_BASE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        phase,
  output logic              seen_q,
  output logic              own_first_q,
  output logic              seen_d,
  output logic              own_first_d,
  output logic              bad_access
);
  import wa_pkg::*;

  localparam logic [DATA_W-1:0] OWN_BAR   = DATA_W'(barrier_value(OWN_BASE));
  localparam logic [DATA_W-1:0] OTHER_BAR = DATA_W'(barrier_value(OTHER_BASE));

  logic bar_done_q;
  logic bar_write;
  logic obs_hit;
  logic wr_bad;
  logic rd_bad;

  // own barrier write seen on the trace
  assign bar_write = vld && wr && (phase == PH_AT) && (data == OWN_BAR);
  // first read returning the other agent's barrier value
  assign obs_hit   = vld && !wr && (data == OTHER_BAR) && !seen_q;

  assign wr_bad = (phase == PH_RSV) ||
                  (int'(data) != mark_value(OWN_BASE, int'(phase)));
  assign rd_bad = !in_set(OWN_BASE, int'(data)) && !in_set(OTHER_BASE, int'(data));
  assign bad_access = vld && (wr ? wr_bad : rd_bad);

  assign seen_d      = seen_q || obs_hit;
  assign own_first_d = obs_hit ? bar_done_q : own_first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_done_q  <= 1'b0;
      seen_q      <= 1'b0;
      own_first_q <= 1'b0;
    end else begin
      bar_done_q  <= bar_done_q || bar_write;
      seen_q      <= seen_d;
      own_first_q <= own_first_d;
    end
  end

  assert_seen_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);
  assert_order_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(own_first_q));
  assert_order_needs_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    own_first_q |-> seen_q);
  assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(seen_q));
endmodule

// File: rtl/wa_agree_chk.sv
module wa_agree_chk #(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a0_vld,
  input  logic              a0_wr,
  input  logic [DATA_W-1:0] a0_data,
  input  logic [1:0]        a0_phase,
  input  logic              a1_vld,
  input  logic              a1_wr,
  input  logic [DATA_W-1:0] a1_data,
  input  logic [1:0]        a1_phase,
  output logic              disagree,
  output logic              illegal,
  output logic              a0_seen,
  output logic              a0_own_first,
  output logic              a1_seen,
  output logic              a1_own_first
);
  import wa_pkg::*;

  localparam int N_AGENTS = 2;

  logic              vld_v       [N_AGENTS];
  logic              wr_v        [N_AGENTS];
  logic [DATA_W-1:0] data_v      [N_AGENTS];
  logic [1:0]        phase_v     [N_AGENTS];
  logic              seen_q_v    [N_AGENTS];
  logic              of_q_v      [N_AGENTS];
  logic              seen_d_v    [N_AGENTS];
  logic              of_d_v      [N_AGENTS];
  logic              bad_v       [N_AGENTS];

  logic disagree_q;
  logic illegal_q;
  logic both_seen_d;
  logic views_clash_d;
  logic any_bad;

  assign vld_v[0] = a0_vld;   assign vld_v[1] = a1_vld;
  assign wr_v[0]  = a0_wr;    assign wr_v[1]  = a1_wr;
  assign data_v[0] = a0_data; assign data_v[1] = a1_data;
  assign phase_v[0] = a0_phase; assign phase_v[1] = a1_phase;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    wa_agent_track #(
      .DATA_W     (DATA_W),
      .OWN_BASE   (agent_base(g)),
      .OTHER_BASE (agent_base(N_AGENTS - 1 - g))
    ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld         (vld_v[g]),
      .wr          (wr_v[g]),
      .data        (data_v[g]),
      .phase       (phase_v[g]),
      .seen_q      (seen_q_v[g]),
      .own_first_q (of_q_v[g]),
      .seen_d      (seen_d_v[g]),
      .own_first_d (of_d_v[g]),
      .bad_access  (bad_v[g])
    );
  end

  // each agent claiming the same side of the order means opposite global orders
  assign both_seen_d   = seen_d_v[0] && seen_d_v[1];
  assign views_clash_d = both_seen_d && (of_d_v[0] == of_d_v[1]);
  assign any_bad       = bad_v[0] || bad_v[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disagree_q <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      disagree_q <= disagree_q || views_clash_d;
      illegal_q  <= illegal_q || any_bad;
    end
  end

  assign disagree     = disagree_q;
  assign illegal      = illegal_q;
  assign a0_seen      = seen_q_v[0];
  assign a0_own_first = of_q_v[0];
  assign a1_seen      = seen_q_v[1];
  assign a1_own_first = of_q_v[1];

  assert_disagree_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disagree_q |=> disagree_q);
  assert_illegal_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |=> illegal_q);
  assert_disagree_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disagree_q |-> (seen_q_v[0] && seen_q_v[1]));
  assert_clash_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q_v[0] && seen_q_v[1] && (of_q_v[0] == of_q_v[1])) |-> disagree_q);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !disagree_q && !illegal_q);
endmodule

// File: tb/wa_agree_chk_bench.sv
`timescale 1ns/1ps
module wa_agree_chk_bench;
  localparam int DW = 3;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0_vld = 0, a0_wr = 0, a1_vld = 0, a1_wr = 0;
  logic [DW-1:0] a0_data = '0, a1_data = '0;
  logic [1:0] a0_phase = '0, a1_phase = '0;
  logic disagree, illegal, a0_seen, a0_own_first, a1_seen, a1_own_first;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wa_agree_chk #(.DATA_W(DW)) u_wa_agree_chk (
    .clk(clk), .rst_n(rst_n),
    .a0_vld(a0_vld), .a0_wr(a0_wr), .a0_data(a0_data), .a0_phase(a0_phase),
    .a1_vld(a1_vld), .a1_wr(a1_wr), .a1_data(a1_data), .a1_phase(a1_phase),
    .disagree(disagree), .illegal(illegal),
    .a0_seen(a0_seen), .a0_own_first(a0_own_first),
    .a1_seen(a1_seen), .a1_own_first(a1_own_first)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a0_vld = 0; a1_vld = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one access on one agent; returns at the falling edge after the capturing rising edge
  task automatic acc(int ag, bit wr, int d, int ph);
    if (ag == 0) begin
      a0_vld = 1; a0_wr = wr; a0_data = DW'(d); a0_phase = 2'(ph);
    end else begin
      a1_vld = 1; a1_wr = wr; a1_data = DW'(d); a1_phase = 2'(ph);
    end
    @(negedge clk);
    a0_vld = 0; a1_vld = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bench model of the value scheme
  function automatic int base_of(int ag); return ag * 3; endfunction
  function automatic bit exp_bad(int ag, bit wr, int d, int ph);
    if (wr) return (ph == 3) || (d != base_of(ag) + ph);
    return d > 5;
  endfunction
  function automatic int other_bar(int ag); return base_of(1 - ag) + 1; endfunction

  initial begin
    do_reset();
    chk("R1 disagree", disagree, 0);
    chk("R1 illegal", illegal, 0);
    chk("R1 a0_seen", a0_seen, 0);
    chk("R1 a1_seen", a1_seen, 0);
    chk("R1 own_first", a0_own_first + a1_own_first, 0);

    // exhaustive single-access sweep: R2 R3 R4
    for (int ag = 0; ag < 2; ag++)
      for (int w = 0; w < 2; w++)
        for (int ph = 0; ph < 4; ph++)
          for (int d = 0; d < 8; d++) begin
            if (w == 0 && ph != 0) continue;
            do_reset();
            acc(ag, bit'(w), d, ph);
            chk(w ? "R2 write illegal" : "R3 read illegal",
                illegal, int'(exp_bad(ag, bit'(w), d, ph)));
            chk("R4 seen", ag == 0 ? a0_seen : a1_seen,
                int'(w == 0 && d == other_bar(ag)));
          end

    // R8: idle cycles with garbage on the ports
    do_reset();
    a0_wr = 0; a0_data = 3'd4; a0_phase = 2'd3;
    a1_wr = 1; a1_data = 3'd7; a1_phase = 2'd3;
    idle(3);
    chk("R8 idle illegal", illegal, 0);
    chk("R8 idle a0_seen", a0_seen, 0);
    chk("R8 idle a1_seen", a1_seen, 0);

    // order sweep: R5 R6 R7
    for (int b0 = 0; b0 < 2; b0++)
      for (int b1 = 0; b1 < 2; b1++) begin
        do_reset();
        acc(0, 1, 0, 0);
        acc(1, 1, 3, 0);
        if (b0) acc(0, 1, 1, 1);
        if (b1) acc(1, 1, 4, 1);
        acc(0, 0, 3, 0);
        chk("R4 pre value not seen", a0_seen, 0);
        acc(0, 0, 4, 0);
        chk("R4 a0 seen", a0_seen, 1);
        chk("R5 a0 own_first", a0_own_first, b0);
        chk("R6 one side only", disagree, 0);
        acc(1, 0, 1, 0);
        chk("R4 a1 seen", a1_seen, 1);
        chk("R5 a1 own_first", a1_own_first, b1);
        chk("R6 disagree", disagree, int'(b0 == b1));
        if (!b0) acc(0, 1, 1, 1);
        acc(0, 1, 2, 2);
        acc(0, 0, 4, 0);
        chk("R5 a0 frozen", a0_own_first, b0);
        chk("R3 legal read", illegal, 0);
        acc(1, 0, 6, 0);
        chk("R3 read 6", illegal, 1);
        idle(4);
        chk("R7 illegal sticky", illegal, 1);
        chk("R7 disagree held", disagree, int'(b0 == b1));
      end

    // both agents observe in the same cycle after both barrier writes
    do_reset();
    a0_vld = 1; a0_wr = 1; a0_data = 3'd1; a0_phase = 2'd1;
    a1_vld = 1; a1_wr = 1; a1_data = 3'd4; a1_phase = 2'd1;
    @(negedge clk);
    a0_wr = 0; a0_data = 3'd4; a1_wr = 0; a1_data = 3'd1;
    @(negedge clk);
    a0_vld = 0; a1_vld = 0;
    chk("R6 simultaneous disagree", disagree, 1);
    chk("R5 simultaneous a0", a0_own_first, 1);
    chk("R5 simultaneous a1", a1_own_first, 1);
    idle(5);
    chk("R7 disagree sticky", disagree, 1);
    do_reset();
    chk("R1 disagree cleared", disagree, 0);
    chk("R1 seen cleared", a0_seen + a1_seen, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule